// File: doc/BRIEF.md
# Ethernet Transmit Framer with Frame Check Sequence

This block turns frames held in a byte-addressed transmit buffer into a byte-wide transmit stream of the kind a gigabit media-independent interface expects: a data byte plus an enable, one byte per clock. Each frame in the buffer starts with a two-byte length header. The payload bytes follow it directly. A producer appends frames and then moves its base pointer forward. The framer registers that pointer once more, for timing. When the registered pointer differs from the framer's own pointer, the framer reads the header and sends the preamble and start delimiter. It then sends exactly the stated number of payload bytes and a 32-bit frame check sequence, which it computes as the bytes go out. At the end it moves its pointer past the frame and pulses a completion strobe.

The read address goes straight to the buffer, and data is expected back in the same cycle. The address never runs past the last byte of the frame being sent. Between frames the framer keeps the line idle for a guard interval before it will look at the producer's pointer again.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, `tx_en` is 0, `tx_data` is 0x00, `frame_done` is 0 and `rd_addr` is 0.
- R2: Each frame begins with seven bytes of 0x55 and then one byte of 0xD5 on `tx_data`, with `tx_en` high. Bit 0 of `tx_data` is the first bit on the wire.
- R3: A frame at base address B holds its length L at B (bits 15:8) and B+1 (bits 7:0). The payload is at B+2 up to B+1+L. Exactly L payload bytes are sent, in address order, right after the 0xD5 byte.
- R4: While `tx_en` is high, `rd_addr` minus B (modulo the buffer size) never exceeds L+1.
- R5: The four bytes after the payload are the complement of the CRC-32 of the payload. The CRC uses the reflected polynomial 0xEDB88320 and an all-ones preset. Bits 7:0 of the complemented value go out first and bits 31:24 go out last.
- R6: `tx_en` stays high without a gap from the first preamble byte to the last check byte, so it is high for exactly 12+L cycles.
- R7: `frame_done` is high for exactly one cycle per frame: the first cycle in which `tx_en` is low again.
- R8: A frame starts only when the registered producer pointer differs from the framer pointer. After a frame, the framer pointer equals B+2+L. Two frames queued by a single pointer move both go out, one after the other.
- R9: At least 12 cycles with `tx_en` low separate the end of one frame from the start of the next.
- R10: A frame with L = 0 sends the preamble, 0xD5 and the four check bytes 0x00, 0x00, 0x00, 0x00, and `rd_addr` stays within B+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_ptr | input | AW | Producer's base pointer, one past the last queued frame |
| rd_addr | output | AW | Buffer read address |
| rd_data | input | 8 | Buffer byte at `rd_addr`, same cycle |
| tx_data | output | 8 | Transmit byte, bit 0 first on the wire |
| tx_en | output | 1 | Transmit enable |
| frame_done | output | 1 | One-cycle completion strobe |

## Verification
A CRC register that is preset wrongly or fed the wrong bytes shows up only in the four check bytes at the end of a frame. So every frame's last bytes are compared against a separately computed CRC-32, including the all-zero 60-byte frame and the frame with set address fields. A miscounted length or a wrong pointer update shows up in the same frame as a changed `tx_en` width or a shifted payload. If the pointer itself is wrong, the effect appears in the following frame as a stray or missing transmission. The read address is watched in every enabled cycle, so an overrun past the last byte is caught in the cycle where it happens.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_LENH, S_LENL, S_PRE, S_SFD, S_DATA, S_FCS, S_GAP
    } txf_state_e;

    // Reflected CRC-32 update with one byte, least significant bit first
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/txf_ptr_stage.sv
module txf_ptr_stage #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ptr_in,
    output logic [AW-1:0] ptr_out
);
    logic [AW-1:0] ptr_d, ptr_q;

    always_comb ptr_d = ptr_in;

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_out = ptr_q;
endmodule

// File: rtl/txf_crc_unit.sv
module txf_crc_unit
    import eth_txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        preset,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (preset)    crc_d = 32'hFFFF_FFFF;
        else if (step) crc_d = crc32_step(crc_q, din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= 32'hFFFF_FFFF;
        else        crc_q <= crc_d;
    end

    assign fcs = ~crc_q;

    // r5_: a preset always leaves the all-ones value in the register
    p_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (fcs == 32'h0));
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_txf_pkg::*;
#(
    parameter int AW        = 12,
    parameter int PRE_BYTES = 7,
    parameter int GAP_BYTES = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] prod_ptr,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic [7:0]    tx_data,
    output logic          tx_en,
    output logic          frame_done
);
    localparam int LW      = 16;
    localparam int CNT_TOP = (GAP_BYTES > PRE_BYTES) ? GAP_BYTES : PRE_BYTES;
    localparam int CW      = $clog2(CNT_TOP);
    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    typedef struct packed {
        txf_state_e    state;
        logic [AW-1:0] ptr;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic [LW-1:0] rem;
        logic [CW-1:0] cnt;
        logic [1:0]    fidx;
        logic [7:0]    txd;
        logic          txen;
        logic          done;
    } txf_regs_t;

    txf_regs_t     r_d, r_q;
    logic [AW-1:0] prod_q;
    logic [31:0]   fcs;
    logic          crc_preset, crc_step;

    txf_ptr_stage #(.AW(AW)) u_ptr_stage (
        .clk(clk), .rst_n(rst_n), .ptr_in(prod_ptr), .ptr_out(prod_q)
    );

    assign crc_preset = (r_q.state == S_SFD);
    assign crc_step   = (r_q.state == S_DATA);

    txf_crc_unit u_crc (
        .clk(clk), .rst_n(rst_n), .preset(crc_preset), .step(crc_step),
        .din(rd_data), .fcs(fcs)
    );

    always_comb begin
        r_d      = r_q;
        r_d.txd  = 8'h00;
        r_d.txen = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                r_d.addr = r_q.ptr;
                if (prod_q != r_q.ptr) r_d.state = S_LENH;
            end
            S_LENH: begin
                r_d.len[15:8] = rd_data;
                r_d.addr      = r_q.addr + AW'(1);
                r_d.state     = S_LENL;
            end
            S_LENL: begin
                r_d.len[7:0] = rd_data;
                r_d.rem      = {r_q.len[15:8], rd_data};
                if ({r_q.len[15:8], rd_data} != '0) r_d.addr = r_q.addr + AW'(1);
                r_d.cnt   = '0;
                r_d.state = S_PRE;
            end
            S_PRE: begin
                r_d.txd  = PRE_BYTE;
                r_d.txen = 1'b1;
                r_d.cnt  = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(PRE_BYTES - 1)) r_d.state = S_SFD;
            end
            S_SFD: begin
                r_d.txd   = SFD_BYTE;
                r_d.txen  = 1'b1;
                r_d.fidx  = 2'd0;
                r_d.state = (r_q.len == '0) ? S_FCS : S_DATA;
            end
            S_DATA: begin
                r_d.txd  = rd_data;
                r_d.txen = 1'b1;
                r_d.rem  = r_q.rem - LW'(1);
                if (r_q.rem == LW'(1)) r_d.state = S_FCS;
                else                   r_d.addr  = r_q.addr + AW'(1);
            end
            S_FCS: begin
                r_d.txd  = fcs[8*r_q.fidx +: 8];
                r_d.txen = 1'b1;
                r_d.fidx = r_q.fidx + 2'd1;
                if (r_q.fidx == 2'd3) begin
                    r_d.ptr   = r_q.ptr + AW'(r_q.len) + AW'(2);
                    r_d.cnt   = '0;
                    r_d.state = S_GAP;
                end
            end
            S_GAP: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(GAP_BYTES - 1)) r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
        r_d.done = r_q.txen & ~r_d.txen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr    = r_q.addr;
    assign tx_data    = r_q.txd;
    assign tx_en      = r_q.txen;
    assign frame_done = r_q.done;

    // R2: the first enabled byte of every frame is a preamble byte
    p_first_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (tx_data == PRE_BYTE));
    // R4: the payload read address stays inside the current frame
    p_addr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_DATA) |->
            ((LW+1)'(AW'(rd_addr - r_q.ptr)) <= ((LW+1)'(r_q.len) + (LW+1)'(1))));
    // R6: enable is held through the start delimiter, payload and check bytes
    p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_SFD || r_q.state == S_DATA || r_q.state == S_FCS) |=> tx_en);
    // R7: completion strobe marks a falling enable and lasts one cycle
    p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!tx_en && $past(tx_en)));
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R9: no frame begins while the guard interval runs
    p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_GAP) |=> !tx_en);
endmodule

// File: tb/eth_tx_framer_bench.sv
module eth_tx_framer_bench;
    localparam int AW   = 12;
    localparam int MSZ  = 1 << AW;
    localparam int NVEC = 5;
    // vector table: payload length, pattern kind, seed
    localparam int V_LEN  [NVEC] = '{60, 60, 1, 5, 64};
    localparam int V_KIND [NVEC] = '{0, 1, 2, 3, 2};
    localparam int V_SEED [NVEC] = '{0, 0, 8'hA7, 8'h3C, 8'h10};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] prod_ptr = '0;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic [7:0]    tx_data;
    logic          tx_en;
    logic          frame_done;

    logic [7:0] mem [0:MSZ-1];
    logic [7:0] cap [0:MSZ-1];
    logic [7:0] expb [0:MSZ-1];
    int nc, ne;
    int checks = 0, fails = 0;
    int done_cnt = 0;
    bit done_bad = 0, addr_bad = 0, lim_on = 0, prev_txen = 0, prev_done = 0;
    bit had_fall = 0;
    int low_run = 0, min_gap = 1000000;
    int cur_base = 0, cur_len = 0, base = 0;

    always #5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    eth_tx_framer u_eth_tx_framer (
        .clk(clk), .rst_n(rst_n), .prod_ptr(prod_ptr), .rd_addr(rd_addr),
        .rd_data(rd_data), .tx_data(tx_data), .tx_en(tx_en), .frame_done(frame_done)
    );

    // port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en) begin
                cap[nc % MSZ] = tx_data;
                nc = nc + 1;
                if (lim_on && (((int'(rd_addr) - cur_base) & (MSZ - 1)) > cur_len + 1))
                    addr_bad = 1;
                if (!prev_txen && had_fall && low_run < min_gap) min_gap = low_run;
            end else begin
                if (prev_txen) begin had_fall = 1; low_run = 0; end
                low_run = low_run + 1;
            end
            if (frame_done) begin
                done_cnt = done_cnt + 1;
                if (!(prev_txen && !tx_en) || prev_done) done_bad = 1;
            end
            prev_txen = tx_en;
            prev_done = frame_done;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pay_byte(input int kind, input int seed, input int i);
        case (kind)
            0: return 8'h00;
            1: begin
                case (i)
                    2: return 8'h3F; 4: return 8'h01;
                    8: return 8'h3F; 11: return 8'h04;
                    12: return 8'h01; 13: return 8'h01;
                    default: return 8'h00;
                endcase
            end
            2: return 8'(seed + i);
            default: return 8'(seed ^ (i * 37));
        endcase
    endfunction

    // independent byte-serial CRC-32 reference
    function automatic logic [31:0] ref_fcs(input int b0, input int len);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'h0, mem[(b0 + 2 + i) % MSZ]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic load_frame(input int b0, input int len, input int kind, input int seed);
        mem[b0 % MSZ]       = 8'(len >> 8);
        mem[(b0 + 1) % MSZ] = 8'(len);
        for (int i = 0; i < len; i++) mem[(b0 + 2 + i) % MSZ] = pay_byte(kind, seed, i);
    endtask

    task automatic add_expected(input int b0, input int len);
        logic [31:0] f;
        for (int i = 0; i < 7; i++) begin expb[ne] = 8'h55; ne++; end
        expb[ne] = 8'hD5; ne++;
        for (int i = 0; i < len; i++) begin expb[ne] = mem[(b0 + 2 + i) % MSZ]; ne++; end
        f = ref_fcs(b0, len);
        for (int i = 0; i < 4; i++) begin expb[ne] = f[8*i +: 8]; ne++; end
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (done_cnt < target && t < 5000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_frame(input int len, input int kind, input int seed);
        int d0, bad;
        load_frame(base, len, kind, seed);
        ne = 0;
        add_expected(base, len);
        @(negedge clk);
        nc = 0; addr_bad = 0; done_bad = 0;
        cur_base = base; cur_len = len; lim_on = 1;
        d0 = done_cnt;
        prod_ptr = AW'(base + 2 + len);
        wait_done(d0 + 1);
        lim_on = 0;
        check(nc == 12 + len, "R6 enable width", nc, 12 + len);
        bad = 0;
        for (int i = 0; i < 8; i++) if (cap[i] != expb[i]) bad++;
        check(bad == 0, "R2 preamble/SFD", bad, 0);
        bad = 0;
        for (int i = 8; i < 8 + len; i++) if (cap[i] != expb[i]) bad++;
        check(bad == 0, "R3 payload", bad, 0);
        check({cap[len+11], cap[len+10], cap[len+9], cap[len+8]} == ref_fcs(base, len),
              "R5 fcs", {cap[len+11], cap[len+10], cap[len+9], cap[len+8]}, ref_fcs(base, len));
        check(!addr_bad, "R4 read address bound", addr_bad, 0);
        check(done_cnt == d0 + 1 && !done_bad, "R7 done strobe", done_cnt - d0, 1);
        base = (base + 2 + len) % MSZ;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int d0, bad;
        nc = 0; ne = 0;
        for (int i = 0; i < MSZ; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_en == 0 && tx_data == 8'h00 && frame_done == 0 && rd_addr == '0,
              "R1 reset outputs", {tx_en, frame_done, tx_data}, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        // R8: no frame while the pointers are equal
        check(nc == 0 && done_cnt == 0, "R8 idle with equal pointers", nc, 0);

        for (int v = 0; v < NVEC; v++) run_frame(V_LEN[v], V_KIND[v], V_SEED[v]);

        // R10: empty payload
        run_frame(0, 0, 0);
        check(cap[8] == 0 && cap[9] == 0 && cap[10] == 0 && cap[11] == 0,
              "R10 empty frame check bytes", {cap[11], cap[10], cap[9], cap[8]}, 0);

        // R8 / R9: two frames queued by a single pointer move
        load_frame(base, 3, 2, 8'h61);
        load_frame(base + 5, 9, 3, 8'h5A);
        ne = 0;
        add_expected(base, 3);
        add_expected(base + 5, 9);
        @(negedge clk);
        nc = 0; done_bad = 0; min_gap = 1000000;
        d0 = done_cnt;
        prod_ptr = AW'(base + 5 + 11);
        wait_done(d0 + 2);
        check(nc == ne, "R8 two queued frames length", nc, ne);
        bad = 0;
        for (int i = 0; i < ne; i++) if (cap[i] != expb[i]) bad++;
        check(bad == 0, "R8 two queued frames content", bad, 0);
        check(min_gap >= 12, "R9 inter-frame gap", min_gap, 12);
        check(done_cnt == d0 + 2 && !done_bad, "R7 done per frame", done_cnt - d0, 2);
        base = (base + 16) % MSZ;

        // R8: framer pointer landed on the new base, nothing more is sent
        nc = 0;
        repeat (50) @(negedge clk);
        check(nc == 0, "R8 no extra frame", nc, 0);
        check(rd_addr == AW'(base), "R8 framer pointer after frames", rd_addr, base);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule